// File: doc/BRIEF.md
# Packet Burst Segmenter with Channel Map

The block sits between a buffered packet pool and a streaming egress interface. Packets arrive one byte per transfer on a valid/ready input, each carrying an 8-bit logical identifier. On the first byte of a packet the identifier indexes a 256-entry programmable table. Each entry holds a logical port number and an enable flag. Packets whose entry is enabled are cut into bursts of a programmable length and forwarded. Every byte of the packet carries the mapped port, and flags mark the first and last byte of each burst and the last byte of the packet. Packets whose entry is disabled are consumed and discarded, and a drop counter records each one.

A global enable gates the egress. While it is clear, no new burst is pulled from the pool. Burst length is one setting for the whole egress, clamped to 16..256 bytes. The port, the enable verdict and the burst length are all captured at the packet's first byte, so software may rewrite the table or the burst length at any time without disturbing a packet in flight. The datapath has no storage: a byte crosses from input to output in the cycle it is accepted, and output backpressure stalls the input directly.

Top module: `burst_segmenter`

## Requirements
- R1: The map holds 256 entries indexed directly by the 8-bit identifier. An entry is written through map_we_i/map_lid_i/map_port_i/map_en_i, and every output byte of an enabled packet carries that entry's port on out_port_o.
- R2: A packet whose entry has enable 0 is accepted in full with no output byte, and drop_cnt_o increments by exactly 1 when its first byte is accepted.
- R3: While the global enable is 0, the block accepts no byte that would start a burst: in_ready_o and out_valid_o stay 0 at a burst boundary. Traffic resumes when the enable is set to 1.
- R4: With effective burst length L, a packet of N bytes leaves as bursts of exactly L bytes, followed by one final burst of N mod L bytes when that is non-zero. out_sob_o is 1 on the first byte of each burst, out_eob_o on the last byte of each burst, and out_eop_o on the last byte of the packet, which always also carries out_eob_o.
- R5: The 9-bit burst-length setting glob_blen_i is clamped: values below 16 act as 16, values above 256 act as 256, and values in between are used unchanged.
- R6: Port, enable verdict and burst length are sampled at a packet's first byte and held for the whole packet. Writes to the map or the burst length during a packet take effect from the next packet.
- R7: Bytes leave in arrival order, and the bursts of one packet are contiguous, with no bytes of another packet between them.
- R8: Output backpressure (out_ready_i low) stalls the input with no loss or duplication of bytes.
- R9: After reset, out_valid_o, in_ready_o and drop_cnt_o are 0, the global enable is 0, the burst setting is 16, and every map entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| in_data_i | input | 8 | Input data byte |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| in_lid_i | input | 8 | Logical identifier, sampled on the first byte |
| map_we_i | input | 1 | Map entry write strobe |
| map_lid_i | input | 8 | Map entry index |
| map_port_i | input | PORT_W | Port written into the entry |
| map_en_i | input | 1 | Enable written into the entry |
| glob_we_i | input | 1 | Global setting write strobe |
| glob_en_i | input | 1 | Global egress enable |
| glob_blen_i | input | 9 | Raw burst length in bytes |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output data byte |
| out_port_o | output | PORT_W | Mapped logical port |
| out_sob_o | output | 1 | First byte of a burst |
| out_eob_o | output | 1 | Last byte of a burst |
| out_eop_o | output | 1 | Last byte of a packet |
| drop_cnt_o | output | DROP_W | Count of discarded packets |

## Verification
On every cycle the assertions check the burst flags: a burst start follows each burst end, no burst exceeds 256 bytes, and a packet end also closes its burst. They also check that the port stays constant within a packet, that no burst starts while the egress is disabled, that a stalled output blocks the input, and that the drop counter only steps by one. The exact burst sizes for a given clamped setting, the dropping of disabled identifiers, and the rule that map and length writes apply only from the next packet can be shown only by the bench scenarios. These run against a queue-based model that predicts every byte and flag under random backpressure.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned LID_W    = 8;
  localparam int unsigned N_LID    = 1 << LID_W;
  localparam int unsigned BLEN_W   = 9;
  localparam int unsigned BLEN_MIN = 16;
  localparam int unsigned BLEN_MAX = 256;

  typedef logic [BLEN_W-1:0] blen_t;
  typedef logic [LID_W-1:0]  lid_t;

  function automatic blen_t clamp_blen(input blen_t raw);
    if (raw < blen_t'(BLEN_MIN))      return blen_t'(BLEN_MIN);
    else if (raw > blen_t'(BLEN_MAX)) return blen_t'(BLEN_MAX);
    else                              return raw;
  endfunction
endpackage

// File: rtl/seg_map_table.sv
module seg_map_table
  import seg_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  lid_t              wr_lid_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic              wr_en_i,
  input  lid_t              rd_lid_i,
  output logic [PORT_W-1:0] rd_port_o,
  output logic              rd_en_o
);
  logic [PORT_W-1:0] port_q [N_LID];
  logic [N_LID-1:0]  en_q;

  for (genvar g = 0; g < N_LID; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        port_q[g] <= '0;
        en_q[g]   <= 1'b0;
      end else if (we_i && wr_lid_i == lid_t'(g)) begin
        port_q[g] <= wr_port_i;
        en_q[g]   <= wr_en_i;
      end
    end
  end

  assign rd_port_o = port_q[rd_lid_i];
  assign rd_en_o   = en_q[rd_lid_i];
endmodule

// File: rtl/seg_cfg.sv
module seg_cfg
  import seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  logic  en_i,
  input  blen_t blen_i,
  output logic  en_o,
  output blen_t blen_eff_o
);
  blen_t blen_raw_q;
  logic  en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      blen_raw_q <= blen_t'(BLEN_MIN);
    end else if (we_i) begin
      en_q       <= en_i;
      blen_raw_q <= blen_i;
    end
  end

  assign en_o       = en_q;
  assign blen_eff_o = clamp_blen(blen_raw_q);
endmodule

// File: rtl/seg_cutter.sv
module seg_cutter
  import seg_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [PORT_W-1:0] lk_port_i,
  input  logic              lk_en_i,
  input  logic              glob_en_i,
  input  blen_t             blen_eff_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_sob_o,
  output logic              out_eob_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              in_pkt_q, drop_q;
  logic [PORT_W-1:0] port_q;
  blen_t             blen_q, cnt_q;
  logic [DROP_W-1:0] drop_cnt_q;

  logic              first, drop_cur, gate, last_b, xfer;
  blen_t             cnt_cur, blen_cur;

  // first byte: explicit start, or any byte after a completed packet
  assign first    = in_sop_i | ~in_pkt_q;
  assign drop_cur = first ? ~lk_en_i   : drop_q;
  assign cnt_cur  = first ? '0         : cnt_q;
  assign blen_cur = first ? blen_eff_i : blen_q;
  // disabled egress holds back burst starts; an in-progress drop drains
  assign gate     = ~glob_en_i & (cnt_cur == '0) & (first | ~drop_q);
  assign last_b   = in_eop_i | (cnt_cur == blen_cur - blen_t'(1));

  assign out_valid_o = in_valid_i & ~gate & ~drop_cur;
  assign in_ready_o  = ~gate & (drop_cur | out_ready_i);
  assign xfer        = in_valid_i & in_ready_o;

  assign out_port_o = first ? lk_port_i : port_q;
  assign out_sob_o  = (cnt_cur == '0);
  assign out_eob_o  = last_b;
  assign drop_cnt_o = drop_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q   <= 1'b0;
      drop_q     <= 1'b0;
      port_q     <= '0;
      blen_q     <= blen_t'(BLEN_MIN);
      cnt_q      <= '0;
      drop_cnt_q <= '0;
    end else if (xfer) begin
      in_pkt_q <= ~in_eop_i;
      if (first) begin
        drop_q <= ~lk_en_i;
        port_q <= lk_port_i;
        blen_q <= blen_eff_i;
        if (!lk_en_i) drop_cnt_q <= drop_cnt_q + DROP_W'(1);
      end
      cnt_q <= (drop_cur | last_b) ? '0 : cnt_cur + blen_t'(1);
    end
  end
endmodule

// File: rtl/burst_segmenter.sv
module burst_segmenter
  import seg_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [7:0]        in_lid_i,
  input  logic              map_we_i,
  input  logic [7:0]        map_lid_i,
  input  logic [PORT_W-1:0] map_port_i,
  input  logic              map_en_i,
  input  logic              glob_we_i,
  input  logic              glob_en_i,
  input  logic [8:0]        glob_blen_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_sob_o,
  output logic              out_eob_o,
  output logic              out_eop_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [PORT_W-1:0] lk_port;
  logic              lk_en;
  logic              glob_en;
  blen_t             blen_eff;

  seg_map_table #(.PORT_W(PORT_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (map_we_i),
    .wr_lid_i  (map_lid_i),
    .wr_port_i (map_port_i),
    .wr_en_i   (map_en_i),
    .rd_lid_i  (in_lid_i),
    .rd_port_o (lk_port),
    .rd_en_o   (lk_en)
  );

  seg_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (glob_we_i),
    .en_i       (glob_en_i),
    .blen_i     (glob_blen_i),
    .en_o       (glob_en),
    .blen_eff_o (blen_eff)
  );

  seg_cutter #(.PORT_W(PORT_W), .DROP_W(DROP_W)) u_cut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .lk_port_i   (lk_port),
    .lk_en_i     (lk_en),
    .glob_en_i   (glob_en),
    .blen_eff_i  (blen_eff),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_port_o  (out_port_o),
    .out_sob_o   (out_sob_o),
    .out_eob_o   (out_eob_o),
    .drop_cnt_o  (drop_cnt_o)
  );

  assign out_data_o = in_data_i;
  assign out_eop_o  = in_eop_i;
endmodule

// File: rtl/seg_checker.sv
module seg_checker #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned DROP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [PORT_W-1:0] out_port_o,
  input logic              out_sob_o,
  input logic              out_eob_o,
  input logic              out_eop_o,
  input logic              glob_en,
  input logic [DROP_W-1:0] drop_cnt_o
);
  logic              at_start, in_pkt;
  logic [PORT_W-1:0] port_l;
  logic [8:0]        bcnt;
  logic              oxfer;

  assign oxfer = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      at_start <= 1'b1;
      in_pkt   <= 1'b0;
      port_l   <= '0;
      bcnt     <= '0;
    end else if (oxfer) begin
      at_start <= out_eob_o;
      in_pkt   <= ~out_eop_o;
      port_l   <= out_port_o;
      bcnt     <= out_eob_o ? 9'd0 : bcnt + 9'd1;
    end
  end

  a_r4_sob_after_eob: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_sob_o == at_start));
  a_r4_burst_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (bcnt < 9'd256));
  a_r4_eop_closes_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eop_o) |-> out_eob_o);
  a_r6_port_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && in_pkt) |-> (out_port_o == port_l));
  a_r3_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && at_start) |-> glob_en);
  a_r8_stall_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  a_r2_drop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drop_cnt_o) |-> ((drop_cnt_o - $past(drop_cnt_o)) == DROP_W'(1)));
endmodule

bind burst_segmenter seg_checker #(.PORT_W(PORT_W), .DROP_W(DROP_W)) u_seg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_port_o  (out_port_o),
  .out_sob_o   (out_sob_o),
  .out_eob_o   (out_eob_o),
  .out_eop_o   (out_eop_o),
  .glob_en     (glob_en),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/tb_burst_segmenter.sv
`timescale 1ns/1ps
module tb_burst_segmenter;
  localparam int PW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic in_valid, in_ready, in_sop, in_eop;
  logic [7:0] in_data, in_lid;
  logic map_we, map_en;
  logic [7:0] map_lid;
  logic [PW-1:0] map_port;
  logic glob_we, glob_en;
  logic [8:0] glob_blen;
  logic out_valid, out_ready;
  logic [7:0] out_data;
  logic [PW-1:0] out_port;
  logic out_sob, out_eob, out_eop;
  logic [DW-1:0] drop_cnt;

  burst_segmenter #(.PORT_W(PW), .DROP_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_lid_i(in_lid),
    .map_we_i(map_we), .map_lid_i(map_lid), .map_port_i(map_port), .map_en_i(map_en),
    .glob_we_i(glob_we), .glob_en_i(glob_en), .glob_blen_i(glob_blen),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_port_o(out_port), .out_sob_o(out_sob), .out_eob_o(out_eob),
    .out_eop_o(out_eop), .drop_cnt_o(drop_cnt)
  );

  typedef struct packed {
    logic [7:0]    d;
    logic [PW-1:0] p;
    logic          sob, eob, eop;
  } beat_t;

  beat_t exp_q[$];
  bit            mir_en   [256];
  logic [PW-1:0] mir_port [256];
  int            mir_blen;
  int            n_cmp = 0, n_bad = 0;
  int            rdy_pct = 100;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_ref(input int raw);
    if (raw < 16) return 16;
    if (raw > 256) return 256;
    return raw;
  endfunction

  always @(posedge clk) begin
    #1;
    out_ready = (($urandom % 100) < rdy_pct);
  end

  // reference comparison on every accepted output byte
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R7 unexpected output byte", int'(out_data), -1);
      end else begin
        beat_t e, a;
        e = exp_q.pop_front();
        a = '{d: out_data, p: out_port, sob: out_sob, eob: out_eob, eop: out_eop};
        chk(a == e, "R1 R4 R6 R7 R8 beat {data,port,sob,eob,eop}", int'(a), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic wr_map(input int lid, input int port, input bit en);
    @(posedge clk); #1;
    map_we = 1'b1; map_lid = 8'(lid); map_port = PW'(port); map_en = en;
    @(posedge clk); #1;
    map_we = 1'b0;
    mir_en[lid] = en; mir_port[lid] = PW'(port);
  endtask

  task automatic wr_glob(input bit en, input int raw);
    @(posedge clk); #1;
    glob_we = 1'b1; glob_en = en; glob_blen = 9'(raw);
    @(posedge clk); #1;
    glob_we = 1'b0;
    mir_blen = clamp_ref(raw);
  endtask

  task automatic send_pkt(input int lid, input int len, input int base);
    int bl = mir_blen;
    if (mir_en[lid]) begin
      for (int i = 0; i < len; i++) begin
        beat_t b;
        b.d = 8'(base + i * 7);
        b.p = mir_port[lid];
        b.sob = ((i % bl) == 0);
        b.eob = ((i % bl) == bl - 1) || (i == len - 1);
        b.eop = (i == len - 1);
        exp_q.push_back(b);
      end
    end
    @(posedge clk); #1;
    for (int i = 0; i < len; i++) begin
      bit acc;
      in_valid = 1'b1; in_data = 8'(base + i * 7); in_lid = 8'(lid);
      in_sop = (i == 0); in_eop = (i == len - 1);
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      if (($urandom % 5) == 0) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 R8 all expected bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    int d0, viol;
    rst_n = 1'b0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; in_lid = 0;
    map_we = 0; map_lid = 0; map_port = 0; map_en = 0;
    glob_we = 0; glob_en = 0; glob_blen = 0; out_ready = 1;
    for (int i = 0; i < 256; i++) begin mir_en[i] = 0; mir_port[i] = '0; end
    mir_blen = 16;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R9 in_ready after reset (egress disabled)", in_ready, 0);
    chk(drop_cnt == '0, "R9 drop_cnt after reset", drop_cnt, 0);

    // R9/R2: entries reset disabled, so an unprogrammed identifier is dropped
    wr_glob(1'b1, 40);
    send_pkt(5, 12, 3);
    repeat (3) @(posedge clk); @(negedge clk);
    chk(drop_cnt == 1, "R9 R2 unprogrammed entry dropped", drop_cnt, 1);

    // R4: 100 bytes at L=40 -> 40,40,20; single byte; exact multiple
    wr_map(5, 2, 1'b1);
    rdy_pct = 80;
    send_pkt(5, 100, 10);
    send_pkt(5, 1, 99);
    send_pkt(5, 40, 50);
    drain();

    // R5 clamping
    wr_glob(1'b1, 5);
    send_pkt(5, 50, 1);
    wr_glob(1'b1, 300);
    send_pkt(5, 600, 2);
    wr_glob(1'b1, 256);
    send_pkt(5, 256, 4);
    wr_glob(1'b1, 16);
    send_pkt(5, 17, 6);
    drain();

    // R1 R7: boundary identifiers and alternating ports
    wr_glob(1'b1, 24);
    wr_map(0, 7, 1'b1);
    wr_map(255, 15, 1'b1);
    wr_map(128, 1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      send_pkt((k % 3 == 0) ? 0 : (k % 3 == 1) ? 255 : 128, 20 + k * 9, k * 31);
    end
    drain();

    // R2: disabled entry among enabled traffic
    wr_map(9, 4, 1'b0);
    d0 = int'(drop_cnt);
    send_pkt(0, 30, 8);
    send_pkt(9, 45, 9);
    send_pkt(255, 30, 11);
    drain();
    chk(int'(drop_cnt) == d0 + 1, "R2 drop_cnt step for disabled entry", drop_cnt, d0 + 1);

    // R6: mid-packet map and length writes apply to the next packet only
    rdy_pct = 100;
    wr_glob(1'b1, 32);
    wr_map(7, 3, 1'b1);
    fork
      send_pkt(7, 80, 20);
      begin
        repeat (10) @(posedge clk);
        #1 map_we = 1'b1; map_lid = 8'd7; map_port = 4'd9; map_en = 1'b1;
        glob_we = 1'b1; glob_en = 1'b1; glob_blen = 9'd64;
        @(posedge clk); #1 map_we = 1'b0; glob_we = 1'b0;
        mir_port[7] = 4'd9; mir_blen = 64;
      end
    join
    send_pkt(7, 80, 40);
    drain();

    // R3: global enable gates burst starts
    wr_glob(1'b0, 64);
    fork
      send_pkt(7, 20, 70);
      begin
        viol = 0;
        repeat (30) begin
          @(negedge clk);
          if (out_valid || in_ready) viol++;
        end
        chk(viol == 0, "R3 no transfer while egress disabled", viol, 0);
        chk(exp_q.size() == 20, "R3 nothing consumed while disabled", exp_q.size(), 20);
        wr_glob(1'b1, 64);
      end
    join
    drain();

    // R8: heavy backpressure
    rdy_pct = 30;
    wr_glob(1'b1, 20);
    for (int k = 0; k < 10; k++) send_pkt((k % 2) ? 0 : 128, 15 + k * 11, k * 13);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule